// File: doc/BRIEF.md
# Differential Phase Mapper with Barker Spreading

This block sits in the transmit path of a direct-sequence spread-spectrum modem, after the scrambler. It takes one symbol's worth of data bits at a time. In two-phase mode a symbol carries one bit; in four-phase mode it carries two. Each symbol's bits become a phase step, and the step is added to the phase of the symbol sent before it. The block then multiplies the resulting constellation point by an 11-chip Barker sequence. It emits one signed I/Q chip on every pulse of a chip-rate enable. At an 11 MHz enable this gives 1 Msymbol/s and 11 Mchip/s.

A small state machine controls the block. It has two states. `ST_WAIT_SYM` is idle, with no symbol loaded. `ST_SPREAD` means chips of the current symbol are being issued. The transitions are:
- WAIT_SYM → SPREAD when a symbol is accepted.
- SPREAD → SPREAD on the last chip when a new symbol is accepted in that same cycle (back-to-back hand-over).
- SPREAD → WAIT_SYM on the last chip when no symbol is offered.

A frame-start qualifier travels with an accepted symbol. When it is set, the phase reference is cleared to 0° for that symbol.

Top module: `dsss_diff_spreader`

## Requirements
- R1: While reset is held, `in_ready` is 1, `out_valid` is 0 and `out_i`/`out_q` are 0.
- R2: In two-phase mode (`mode_qpsk`=0), `in_bits[0]`=0 gives a phase step of 0° and `in_bits[0]`=1 gives a step of 180°. `in_bits[1]` has no effect on the output.
- R3: In four-phase mode (`mode_qpsk`=1), the dibit {`in_bits[1]`,`in_bits[0]`} sets the step: 00 is 0°, 01 is +90°, 11 is 180°, 10 is +270°. Phases map to points as follows: 0° is (I=+1,Q=0), 90° is (0,+1), 180° is (−1,0), 270° is (0,−1).
- R4: A symbol's phase equals the previous accepted symbol's phase plus its step, modulo 360°.
- R5: `frame_start` is sampled only on a handshake (`in_valid` and `in_ready` both high). When sampled high, the prior phase is taken as 0°. Asserted without a handshake, it has no effect.
- R6: Each symbol yields exactly 11 chips. Chip k equals c[k] times the symbol point, where c = +1,−1,+1,+1,−1,+1,+1,+1,−1,−1,−1 (chip 0 first). `SPREAD_CODE` bit k set means c[k]=+1.
- R7: The block issues one chip for each cycle in which `chip_en` is high while spreading. `out_valid` is high in the following cycle only. `out_i`/`out_q` hold their value when `out_valid` is low.
- R8: `in_ready` is high in WAIT_SYM. It is also high in the spreading cycle that issues the last chip with `chip_en` high. It is low at all other times, so back-to-back symbols produce an unbroken chip stream.
- R9: Chips are 2-bit two's complement values: +1 is 01, −1 is 11, 0 is 00. The value 10 never appears.
- R10: `mode_qpsk` and `in_bits` are sampled only at the handshake. Changing them during spreading does not affect the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chip_en | input | 1 | Chip-rate enable; one chip per high cycle |
| mode_qpsk | input | 1 | 0: two-phase, 1: four-phase differential mapping |
| frame_start | input | 1 | Clears the phase reference for the accepted symbol |
| in_valid | input | 1 | Symbol bits offered |
| in_bits | input | 2 | Symbol bits; only bit 0 is used in two-phase mode |
| in_ready | output | 1 | Symbol accepted at this edge if `in_valid` is high |
| out_valid | output | 1 | A new chip is on `out_i`/`out_q` |
| out_i | output | 2 | In-phase chip, signed |
| out_q | output | 2 | Quadrature chip, signed |

## Verification
The bench builds the block with its default parameters: an 11-chip code length and the standard Barker pattern. With these, every chip of the real sequence is compared, including the wrap from chip 10 back to chip 0. Two `chip_en` patterns are applied. The first is continuous, which exercises the back-to-back hand-over on the last chip. The second drops every third enable, so the last-chip boundary falls next to disabled cycles. Both sign bits appear in every phase quadrant.

// File: rtl/dsss_pkg.sv
package dsss_pkg;

    localparam int CHIP_W = 2;
    localparam int PH_W   = 2;

    typedef enum logic [0:0] {
        ST_WAIT_SYM = 1'b0,
        ST_SPREAD   = 1'b1
    } spr_state_t;

    // Phase step in quarter turns.
    // Four-phase: Gray-decoded dibit. Two-phase: bit 0 selects a half turn.
    function automatic logic [PH_W-1:0] phase_step(input logic qpsk, input logic [1:0] bits);
        if (qpsk)
            phase_step = {bits[1], bits[1] ^ bits[0]};
        else
            phase_step = bits[0] ? 2'd2 : 2'd0;
    endfunction

endpackage

// File: rtl/dsss_phase_track.sv
module dsss_phase_track
    import dsss_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            restart,
    input  logic [PH_W-1:0] step,
    output logic [PH_W-1:0] phase
);

    logic [PH_W-1:0] base;

    always_comb begin
        base = restart ? '0 : phase;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= '0;
        else if (load)
            phase <= base + step;
    end

    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(phase));                            // R4

    AST_FRAME_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (load && restart) |=> (phase == $past(step)));        // R5

endmodule

// File: rtl/dsss_chip_map.sv
module dsss_chip_map
    import dsss_pkg::*;
#(
    parameter int                CODE_LEN = 11,
    parameter logic [CODE_LEN-1:0] CODE   = 11'b000_1110_1101,
    parameter int                IDX_W    = 4
)(
    input  logic [PH_W-1:0]   phase,
    input  logic [IDX_W-1:0]  idx,
    output logic [CHIP_W-1:0] chip_i,
    output logic [CHIP_W-1:0] chip_q
);

    localparam int EXT_LEN = 1 << IDX_W;
    localparam logic [EXT_LEN-1:0] CODE_EXT = EXT_LEN'(CODE);

    logic [CHIP_W-1:0] sym_i;
    logic [CHIP_W-1:0] sym_q;
    logic              pos;

    always_comb begin
        unique case (phase)
            2'd0:    begin sym_i = 2'b01; sym_q = 2'b00; end
            2'd1:    begin sym_i = 2'b00; sym_q = 2'b01; end
            2'd2:    begin sym_i = 2'b11; sym_q = 2'b00; end
            default: begin sym_i = 2'b00; sym_q = 2'b11; end
        endcase
        pos    = CODE_EXT[idx];
        chip_i = pos ? sym_i : (2'b00 - sym_i);
        chip_q = pos ? sym_q : (2'b00 - sym_q);
    end

endmodule

// File: rtl/dsss_diff_spreader.sv
module dsss_diff_spreader
    import dsss_pkg::*;
#(
    parameter int                  CODE_LEN    = 11,
    parameter logic [CODE_LEN-1:0] SPREAD_CODE = 11'b000_1110_1101
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_en,
    input  logic              mode_qpsk,
    input  logic              frame_start,
    input  logic              in_valid,
    input  logic [1:0]        in_bits,
    output logic              in_ready,
    output logic              out_valid,
    output logic [CHIP_W-1:0] out_i,
    output logic [CHIP_W-1:0] out_q
);

    localparam int                IDX_W    = $clog2(CODE_LEN);
    localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(CODE_LEN - 1);

    spr_state_t        state, state_nx;
    logic [IDX_W-1:0]  chip_idx;
    logic [PH_W-1:0]   sym_phase;
    logic [CHIP_W-1:0] chip_i, chip_q;
    logic              spreading, issue, last_chip, accept;

    always_comb begin
        spreading = (state == ST_SPREAD);
        issue     = spreading && chip_en;
        last_chip = issue && (chip_idx == LAST_IDX);
        in_ready  = (state == ST_WAIT_SYM) || last_chip;
        accept    = in_valid && in_ready;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_WAIT_SYM: if (accept) state_nx = ST_SPREAD;
            ST_SPREAD:   if (last_chip) state_nx = accept ? ST_SPREAD : ST_WAIT_SYM;
            default:     state_nx = ST_WAIT_SYM;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_WAIT_SYM;
        else        state <= state_nx;
    end

    // Output and chip-index registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_i     <= '0;
            out_q     <= '0;
            chip_idx  <= '0;
        end else begin
            out_valid <= issue;
            if (issue) begin
                out_i <= chip_i;
                out_q <= chip_q;
            end
            if (accept)
                chip_idx <= '0;
            else if (issue)
                chip_idx <= chip_idx + 1'b1;
        end
    end

    dsss_phase_track u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .restart (frame_start),
        .step    (phase_step(mode_qpsk, in_bits)),
        .phase   (sym_phase)
    );

    dsss_chip_map #(
        .CODE_LEN (CODE_LEN),
        .CODE     (SPREAD_CODE),
        .IDX_W    (IDX_W)
    ) u_map (
        .phase  (sym_phase),
        .idx    (chip_idx),
        .chip_i (chip_i),
        .chip_q (chip_q)
    );

    AST_OUT_ONE_AXIS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_i == 2'b00) != (out_q == 2'b00)));      // R3

    AST_NO_MINUS_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_i != 2'b10) && (out_q != 2'b10));                      // R9

    AST_VALID_AFTER_EN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(chip_en));                              // R7

    AST_CHIP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(out_i) && $stable(out_q)));         // R7

    AST_READY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (spreading && in_ready) |-> chip_en);                       // R8

endmodule

// File: tb/tb_dsss_diff_spreader.sv
module tb_dsss_diff_spreader;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chip_en = 1'b0;
    logic       mode_qpsk = 1'b0;
    logic       frame_start = 1'b0;
    logic       in_valid = 1'b0;
    logic [1:0] in_bits = 2'b00;
    logic       in_ready, out_valid;
    logic [1:0] out_i, out_q;

    always #10 clk = ~clk;

    dsss_diff_spreader dut (
        .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .mode_qpsk(mode_qpsk),
        .frame_start(frame_start), .in_valid(in_valid), .in_bits(in_bits),
        .in_ready(in_ready), .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    localparam logic [10:0] BK = 11'b000_1110_1101;

    int         n_tests = 0;
    int         n_fail  = 0;
    int         cyc     = 0;
    int         en_mode = 0;
    logic [3:0] expq[$];
    logic [1:0] ref_ph = 2'd0;
    logic       en_seen = 1'b0;
    logic [1:0] last_i = 2'b00, last_q = 2'b00;
    bit         done = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    function automatic logic [1:0] enc(input int v);
        if (v > 0)      return 2'b01;
        else if (v < 0) return 2'b11;
        else            return 2'b00;
    endfunction

    function automatic logic [1:0] step_of(input logic m, input logic [1:0] b);
        if (!m) return b[0] ? 2'd2 : 2'd0;   // R2
        case (b)                              // R3
            2'b00:   return 2'd0;
            2'b01:   return 2'd1;
            2'b11:   return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

    // Driver: call at a point away from edges; ends just after a negedge.
    task automatic send(input logic m, input logic [1:0] b, input logic fs);
        logic [1:0] p;
        int si, sq;
        p = (fs ? 2'd0 : ref_ph) + step_of(m, b);   // R4 R5
        ref_ph = p;
        case (p)
            2'd0: begin si = 1;  sq = 0;  end
            2'd1: begin si = 0;  sq = 1;  end
            2'd2: begin si = -1; sq = 0;  end
            default: begin si = 0; sq = -1; end
        endcase
        for (int k = 0; k < 11; k++) begin
            int c;
            c = BK[k] ? 1 : -1;                        // R6
            expq.push_back({enc(si * c), enc(sq * c)});
        end
        in_valid = 1'b1; mode_qpsk = m; in_bits = b; frame_start = fs;
        #1;
        while (!in_ready) begin @(negedge clk); #3; end
        @(posedge clk); #1;
        in_valid = 1'b0; frame_start = 1'b0;
        mode_qpsk = ~m; in_bits = ~b;                  // R10: changes after handshake
        @(negedge clk); #3;
        check(in_ready == 1'b0, "R8 in_ready low after accept", in_ready, 0);
    endtask

    // Chip enable driver and watchdog
    always @(posedge clk) begin
        #2;
        cyc++;
        chip_en = (en_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                logic [3:0] e;
                check(en_seen == 1'b1, "R7 chip without enable", en_seen, 1);
                if (expq.size() == 0) begin
                    check(1'b0, "R6 unexpected chip", {out_i, out_q}, 0);
                end else begin
                    e = expq.pop_front();
                    // R2 R3 R4 R5 R6 R9 R10
                    check({out_i, out_q} == e, "R6 chip value (R2 R3 R4 R5 R9 R10)", {out_i, out_q}, e);
                end
                last_i = out_i; last_q = out_q;
            end else begin
                check(out_i == last_i && out_q == last_q, "R7 chip hold", {out_i, out_q}, {last_i, last_q});
            end
        end
        en_seen = chip_en;
    end

    initial begin
        logic [7:0] lf;
        repeat (3) @(negedge clk);
        #3;
        check(in_ready == 1'b1, "R1 in_ready in reset", in_ready, 1);
        check(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
        check(out_i == 2'b00 && out_q == 2'b00, "R1 chips in reset", {out_i, out_q}, 0);
        rst_n = 1'b1;
        @(negedge clk); #3;

        // Continuous enable: all four-phase steps, back to back
        en_mode = 0;
        send(1'b1, 2'b00, 1'b1);
        send(1'b1, 2'b01, 1'b0);
        send(1'b1, 2'b11, 1'b0);
        send(1'b1, 2'b10, 1'b0);
        send(1'b1, 2'b01, 1'b0);
        // Two-phase steps; bit 1 must not matter (R2)
        send(1'b0, 2'b00, 1'b0);
        send(1'b0, 2'b01, 1'b0);
        send(1'b0, 2'b10, 1'b0);
        send(1'b0, 2'b11, 1'b0);
        // Frame restart (R5)
        send(1'b1, 2'b11, 1'b1);
        send(1'b1, 2'b01, 1'b1);

        // frame_start without handshake is ignored (R5)
        repeat (20) @(negedge clk);
        #3;
        check(in_ready == 1'b1, "R8 ready while idle", in_ready, 1);
        frame_start = 1'b1;
        repeat (3) @(negedge clk);
        #3;
        frame_start = 1'b0;
        send(1'b1, 2'b01, 1'b0);

        // Thinned enable
        en_mode = 1;
        lf = 8'hA5;
        for (int n = 0; n < 40; n++) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            send(lf[0], lf[2:1], (n % 13) == 5);
        end

        // Drain
        while (expq.size() != 0) @(negedge clk);
        repeat (10) @(negedge clk);
        #3;
        check(out_valid == 1'b0, "R7 no chips when idle", out_valid, 0);
        check(in_ready == 1'b1, "R8 ready after drain", in_ready, 1);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule